// File: doc/BRIEF.md
# Single-Cycle Four-Instruction Datapath

A 32-bit processor core that fetches, decodes, executes, accesses memory and writes back one instruction in every clock cycle. It carries out four operations: a register-to-register bitwise AND, a word load, a word store and a branch taken when two registers are equal. Any other encoding does nothing except move the program counter to the next word. The program counter, the next-address logic, the decoder, a 32-entry register file, a small ALU (AND, add, subtract), the immediate sign extender and two word-addressed memories all sit inside the block. Every state element is clocked on the same rising edge, and no clock is gated.

A test environment holds the core in reset and fills the instruction and data memories through two write ports. Each of these ports also has a combinational read-back path. After reset is released, the environment watches the program counter and reads any architectural register through a debug select port.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and every register reads 0. The memories keep the contents written through the preload ports.
- R2: An instruction that does not branch sets pc_o to pc_o + 4 at the next rising edge, so pc_o[1:0] stays 0.
- R3: A word with opcode bits [31:26] = 6'h00 and function bits [5:0] = 6'h24 writes reg[rs] & reg[rt] into reg[rd]. The fields are rs = [25:21], rt = [20:16] and rd = [15:11].
- R4: Opcode 6'h23 loads reg[rt] with the data word at byte address reg[rs] + sign-extended bits [15:0], and that word is indexed by address bits [9:2]. Negative offsets are included.
- R5: Opcode 6'h2B writes reg[rt] to the data word at the same computed address and changes no register.
- R6: Opcode 6'h04 with reg[rs] == reg[rt] sets pc_o to (pc_o + 4) + (sign-extended [15:0] << 2). This covers forward targets, backward targets and a branch to itself.
- R7: Opcode 6'h04 with reg[rs] != reg[rt] goes to pc_o + 4 and writes nothing.
- R8: Register 0 always reads as 0, even after an instruction names it as the destination.
- R9: Any other opcode, and opcode 6'h00 with a function other than 6'h24, changes no register and no data word. It only advances pc_o by 4.
- R10: A high write-enable on a preload port writes that port's data to word address [7:0] at the rising edge. The matching read-back output shows the word at that address combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_we_i | input | 1 | Instruction memory preload write enable |
| imem_addr_i | input | 8 | Instruction memory preload/read-back word address |
| imem_wdata_i | input | 32 | Instruction memory preload data |
| imem_rdata_o | output | 32 | Instruction memory read-back data |
| dmem_we_i | input | 1 | Data memory preload write enable |
| dmem_addr_i | input | 8 | Data memory preload/read-back word address |
| dmem_wdata_i | input | 32 | Data memory preload data |
| dmem_rdata_o | output | 32 | Data memory read-back data |
| dbg_sel_i | input | 5 | Register read-back select |
| dbg_data_o | output | 32 | Register read-back data |
| pc_o | output | 32 | Current program counter |

## Verification
The bench runs one program and compares the program counter every cycle with a trace worked out by hand. The program includes a forward branch that skips loads, a branch that is not taken, a backward branch to itself and two unknown encodings. A core that used the unincremented PC as the branch base, or that forgot to scale the offset by four, would land on the wrong word and leave the trace. Loads and stores use negative offsets, so a sign extender that filled with zeros would reach the wrong word. The bench then sweeps all 32 registers and all 256 data words. That sweep catches a write to register 0, a register written by a store or by a no-op, and a store that went to the wrong address.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] FN_AND   = 6'h24;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  typedef enum logic [1:0] {ALU_AND, ALU_ADD, ALU_SUB} alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    dst_rt;
    logic    use_imm;
    logic    mem_we;
    logic    wb_mem;
    logic    is_beq;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '{rf_we: 1'b0, dst_rt: 1'b0, use_imm: 1'b0, mem_we: 1'b0,
               wb_mem: 1'b0, is_beq: 1'b0, alu_op: ALU_AND};
    unique case (opcode_i)
      OP_RTYPE: if (funct_i == FN_AND) ctrl_o.rf_we = 1'b1;
      OP_LW: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.dst_rt  = 1'b1;
        ctrl_o.use_imm = 1'b1;
        ctrl_o.wb_mem  = 1'b1;
        ctrl_o.alu_op  = ALU_ADD;
      end
      OP_SW: begin
        ctrl_o.mem_we  = 1'b1;
        ctrl_o.use_imm = 1'b1;
        ctrl_o.alu_op  = ALU_ADD;
      end
      OP_BEQ: begin
        ctrl_o.is_beq = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      default: ;  // unknown encoding: no-op
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] y_o,
  output logic            zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      default: y_o = a_i & b_i;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned RAW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RAW-1:0]  ra_a_i,
  input  logic [RAW-1:0]  ra_b_i,
  output logic [XLEN-1:0] rd_a_o,
  output logic [XLEN-1:0] rd_b_o,
  input  logic            we_i,
  input  logic [RAW-1:0]  wa_i,
  input  logic [XLEN-1:0] wd_i,
  input  logic [RAW-1:0]  dbg_sel_i,
  output logic [XLEN-1:0] dbg_data_o
);
  logic [XLEN-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs_q[g] = '0;
    end else begin : g_ff
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             regs_q[g] <= '0;
        else if (we_i && wa_i == RAW'(g))        regs_q[g] <= wd_i;
      end
    end
  end

  assign rd_a_o     = regs_q[ra_a_i];
  assign rd_b_o     = regs_q[ra_b_i];
  assign dbg_data_o = regs_q[dbg_sel_i];
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic            clk_i,
  input  logic            we_i,
  input  logic [AW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i,
  input  logic [AW-1:0]   ra0_i,
  output logic [XLEN-1:0] rd0_o,
  input  logic [AW-1:0]   ra1_i,
  output logic [XLEN-1:0] rd1_o
);
  logic [XLEN-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wa_i] <= wd_i;
  end

  assign rd0_o = mem_q[ra0_i];
  assign rd1_o = mem_q[ra1_i];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  parameter int unsigned MAW  = 8,
  localparam int unsigned RAW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            imem_we_i,
  input  logic [MAW-1:0]  imem_addr_i,
  input  logic [XLEN-1:0] imem_wdata_i,
  output logic [XLEN-1:0] imem_rdata_o,
  input  logic            dmem_we_i,
  input  logic [MAW-1:0]  dmem_addr_i,
  input  logic [XLEN-1:0] dmem_wdata_i,
  output logic [XLEN-1:0] dmem_rdata_o,
  input  logic [RAW-1:0]  dbg_sel_i,
  output logic [XLEN-1:0] dbg_data_o,
  output logic [XLEN-1:0] pc_o
);
  logic [XLEN-1:0] pc_q, pc_d, pc_inc, br_tgt;
  logic [XLEN-1:0] instr, imm_sx, rs_val, rt_val, alu_b, alu_y, ld_data, wb_data;
  logic [RAW-1:0]  rs_idx, rt_idx, rd_idx, wa;
  logic            alu_zero, rf_we, core_st, dmem_we, take_br;
  ctrl_t           ctrl;
  logic            unused_bits;

  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];
  assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign unused_bits = ^{instr[10:6], pc_q[1:0], pc_q[XLEN-1:MAW+2],
                         alu_y[1:0], alu_y[XLEN-1:MAW+2]};

  sc_mem #(.XLEN(XLEN), .AW(MAW)) u_imem (
    .clk_i, .we_i(imem_we_i), .wa_i(imem_addr_i), .wd_i(imem_wdata_i),
    .ra0_i(pc_q[MAW+1:2]), .rd0_o(instr),
    .ra1_i(imem_addr_i),   .rd1_o(imem_rdata_o)
  );

  sc_decode u_dec (.opcode_i(instr[31:26]), .funct_i(instr[5:0]), .ctrl_o(ctrl));

  assign wa      = ctrl.dst_rt ? rt_idx : rd_idx;
  assign rf_we   = ctrl.rf_we;
  assign wb_data = ctrl.wb_mem ? ld_data : alu_y;

  sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni,
    .ra_a_i(rs_idx), .ra_b_i(rt_idx), .rd_a_o(rs_val), .rd_b_o(rt_val),
    .we_i(rf_we), .wa_i(wa), .wd_i(wb_data),
    .dbg_sel_i, .dbg_data_o
  );

  assign alu_b = ctrl.use_imm ? imm_sx : rt_val;

  sc_alu #(.XLEN(XLEN)) u_alu (
    .a_i(rs_val), .b_i(alu_b), .op_i(ctrl.alu_op), .y_o(alu_y), .zero_o(alu_zero)
  );

  // preload port wins; core stores are held off during reset
  assign core_st = ctrl.mem_we & rst_ni;
  assign dmem_we = dmem_we_i | core_st;

  sc_mem #(.XLEN(XLEN), .AW(MAW)) u_dmem (
    .clk_i, .we_i(dmem_we),
    .wa_i(dmem_we_i ? dmem_addr_i : alu_y[MAW+1:2]),
    .wd_i(dmem_we_i ? dmem_wdata_i : rt_val),
    .ra0_i(alu_y[MAW+1:2]), .rd0_o(ld_data),
    .ra1_i(dmem_addr_i),    .rd1_o(dmem_rdata_o)
  );

  assign pc_inc  = pc_q + XLEN'(4);
  assign br_tgt  = pc_inc + (imm_sx << 2);
  assign take_br = ctrl.is_beq & alu_zero;
  assign pc_d    = take_br ? br_tgt : pc_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] instr_i,
  input logic [XLEN-1:0] imm_i,
  input logic [XLEN-1:0] rs_val_i,
  input logic [XLEN-1:0] rt_val_i,
  input logic            rf_we_i,
  input logic            core_st_i
);
  logic [5:0] op;
  logic       known;
  assign op    = instr_i[31:26];
  assign known = (op == OP_LW) || (op == OP_SW) || (op == OP_BEQ) ||
                 (op == OP_RTYPE && instr_i[5:0] == FN_AND);

  AST_PC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_i[1:0] == 2'b00);  // R2

  AST_SEQ_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OP_BEQ) |=> (pc_i == $past(pc_i) + 32'd4));  // R2

  AST_BEQ_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BEQ && rs_val_i == rt_val_i)
      |=> (pc_i == $past(pc_i) + 32'd4 + ($past(imm_i) << 2)));  // R6

  AST_BEQ_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BEQ && rs_val_i != rt_val_i) |=> (pc_i == $past(pc_i) + 32'd4));  // R7

  AST_STORE_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SW) |-> !rf_we_i);  // R5

  AST_R0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[25:21] == 5'd0) |-> (rs_val_i == '0));  // R8

  AST_NOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known |-> (!rf_we_i && !core_st_i));  // R9
endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pc_i(pc_o), .instr_i(instr), .imm_i(imm_sx),
  .rs_val_i(rs_val), .rt_val_i(rt_val), .rf_we_i(rf_we), .core_st_i(core_st)
);

// File: tb/sc_core_test.sv
module sc_core_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        imem_we_i = 1'b0;
  logic [7:0]  imem_addr_i = '0;
  logic [31:0] imem_wdata_i = '0;
  logic [31:0] imem_rdata_o;
  logic        dmem_we_i = 1'b0;
  logic [7:0]  dmem_addr_i = '0;
  logic [31:0] dmem_wdata_i = '0;
  logic [31:0] dmem_rdata_o;
  logic [4:0]  dbg_sel_i = '0;
  logic [31:0] dbg_data_o;
  logic [31:0] pc_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_reg [32];
  logic [31:0] exp_dm  [256];

  always #5 clk_i = ~clk_i;

  sc_core uut (.*);

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] exp_pc(int k);
    if (k <= 11) return 32'(4 * k);
    if (k == 12) return 32'd56;
    if (k == 13) return 32'd64;
    return 32'd68;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  logic [31:0] prog [18];

  initial begin
    prog[0]  = enc_i(6'h23, 0, 1, 16'd0);
    prog[1]  = enc_i(6'h23, 0, 2, 16'd4);
    prog[2]  = enc_r(1, 2, 3, 6'h24);
    prog[3]  = enc_i(6'h23, 0, 4, 16'd8);
    prog[4]  = enc_i(6'h23, 0, 6, 16'd12);
    prog[5]  = enc_i(6'h23, 6, 7, 16'hFFF0);   // R4 negative offset
    prog[6]  = enc_i(6'h2B, 6, 3, 16'hFFFC);   // R5 store to word 7
    prog[7]  = enc_r(1, 2, 0, 6'h24);          // R8 write to r0
    prog[8]  = enc_i(6'h04, 1, 2, 16'd5);      // R7 not taken
    prog[9]  = {6'h3F, 26'h1234567};           // R9 unknown opcode
    prog[10] = enc_r(1, 2, 8, 6'h20);          // R9 unknown function
    prog[11] = enc_i(6'h04, 1, 1, 16'd2);      // R6 forward
    prog[12] = enc_i(6'h23, 0, 9, 16'd0);      // skipped
    prog[13] = enc_i(6'h23, 0, 9, 16'd4);      // skipped
    prog[14] = enc_i(6'h04, 0, 0, 16'd1);      // R6
    prog[15] = enc_i(6'h23, 0, 11, 16'd0);     // skipped
    prog[16] = enc_r(4, 1, 10, 6'h24);
    prog[17] = enc_i(6'h04, 0, 0, 16'hFFFF);   // R6 self loop

    for (int i = 0; i < 256; i++) exp_dm[i] = 32'hA500_0000 | 32'(i);
    exp_dm[0] = 32'hF0F0_1234;
    exp_dm[1] = 32'h0FF0_FF00;
    exp_dm[2] = 32'h8000_0001;
    exp_dm[3] = 32'd32;
    exp_dm[4] = 32'h5555_AAAA;

    // preload under reset (R10)
    for (int i = 0; i < 256; i++) begin
      @(negedge clk_i);
      imem_we_i = 1'b1; imem_addr_i = 8'(i);
      imem_wdata_i = (i < 18) ? prog[i] : 32'h0;
      dmem_we_i = 1'b1; dmem_addr_i = 8'(i); dmem_wdata_i = exp_dm[i];
    end
    @(negedge clk_i);
    imem_we_i = 1'b0; dmem_we_i = 1'b0;

    imem_addr_i = 8'd11;
    dmem_addr_i = 8'd4;
    #1;
    check(imem_rdata_o == prog[11], "R10 imem readback", imem_rdata_o, prog[11]);
    check(dmem_rdata_o == exp_dm[4], "R10 dmem readback", dmem_rdata_o, exp_dm[4]);
    check(pc_o == 32'd0, "R1 pc in reset", pc_o, 32'd0);
    for (int r = 0; r < 32; r++) begin
      dbg_sel_i = 5'(r); #1;
      check(dbg_data_o == 32'd0, "R1 reg in reset", dbg_data_o, 32'd0);
    end

    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check(pc_o == exp_pc(0), "R1 pc after release", pc_o, exp_pc(0));
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk_i);
      #1;
      check(pc_o == exp_pc(k), "R2/R6/R7 pc trace", pc_o, exp_pc(k));
    end

    for (int r = 0; r < 32; r++) exp_reg[r] = 32'd0;
    exp_reg[1]  = exp_dm[0];
    exp_reg[2]  = exp_dm[1];
    exp_reg[3]  = exp_dm[0] & exp_dm[1];   // R3
    exp_reg[4]  = exp_dm[2];
    exp_reg[6]  = 32'd32;
    exp_reg[7]  = exp_dm[4];               // R4
    exp_reg[10] = exp_dm[2] & exp_dm[0];
    exp_dm[7]   = exp_reg[3];              // R5

    for (int r = 0; r < 32; r++) begin
      dbg_sel_i = 5'(r); #1;
      check(dbg_data_o == exp_reg[r], "R3/R4/R8/R9 reg sweep", dbg_data_o, exp_reg[r]);
    end
    for (int i = 0; i < 256; i++) begin
      dmem_addr_i = 8'(i); #1;
      check(dmem_rdata_o == exp_dm[i], "R5/R9 dmem sweep", dmem_rdata_o, exp_dm[i]);
    end
    finish_run();
  end
endmodule